// File: doc/BRIEF.md
# Sixteen-Bit One-Shot Interval Timer

A 16-bit down-counter sits behind a small 8-bit register bus with two addresses, one for the low byte and one for the high byte. Software stages the low byte in a holding latch. A write of the high byte then loads the whole count at once and arms the interrupt. In interval mode the counter decrements on every system clock. In pulse mode it decrements once for each falling edge of an external pulse input. The pulse input is synchronised on chip before edge detection.

On the step from zero to $FFFF, an armed timer raises its interrupt flag and disarms itself. The counter does not reload. It keeps counting down, so software can read how long ago the time-out happened. No later zero crossing sets the flag until the high byte is written again. A read of the low byte clears the flag, and so does a write of the high byte. The interrupt request is the flag gated by an enable input.

Top module: `oneshot_timer16`

## Requirements
- R1: While reset is active, and after it is released, the counter and the latch are zero, the flag and `irq_o` are 0, and the timer is disarmed.
- R2: A write with `addr_i`=0 loads only the low-byte latch. The counter does not change because of it.
- R3: A write with `addr_i`=1 loads the counter with {`wdata_i`, latch} on that clock edge, clears the flag and arms the timer.
- R4: With `mode_i`=0 and no high-byte write, the counter decrements by one on every clock edge.
- R5: With `mode_i`=1, the counter decrements once for each high-to-low transition of `pulse_i`, at most once per clock. The transition is seen through a two-flop synchroniser, so the decrement lands on the third rising edge after the input falls.
- R6: On the edge where an armed counter steps from 0 to $FFFF, the flag is set and the timer is disarmed. The counter then continues down from $FFFF without reloading.
- R7: A disarmed timer never sets the flag, however many zero crossings occur, until the next high-byte write.
- R8: A read with `addr_i`=0 (`cs_i`=1, `we_i`=0) presents counter bits 7:0 on `rdata_o` and clears the flag on that edge.
- R9: A read with `addr_i`=1 presents counter bits 15:8 and leaves the flag unchanged.
- R10: `irq_o` equals the flag ANDed with `irq_en_i`, combinationally.
- R11: A high-byte write in the same cycle as a time-out wins: the flag ends cleared and the timer stays armed. A low-byte read in the same cycle as a time-out loses: the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus access strobe for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = low byte, 1 = high byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Live counter byte selected by addr_i |
| mode_i | input | 1 | 0 = interval (per clock), 1 = pulse count |
| pulse_i | input | 1 | External asynchronous pulse input |
| irq_en_i | input | 1 | Interrupt request enable |
| flag_o | output | 1 | Interrupt flag |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench drives the counter through a full wrap and a second zero crossing without reloading it. A design that re-arms on wrap, or that reloads from the latch, would raise a second interrupt or show the wrong elapsed count. It places a high-byte write and a low-byte read in exactly the time-out cycle, which exposes a wrong priority as a flag left set or a lost event. It also writes the low byte alone and holds the pulse input low for many cycles. A design that leaks the latch into the counter, or that counts levels instead of edges, shows a drifting count.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
  typedef enum logic {SEL_LO = 1'b0, SEL_HI = 1'b1} byte_sel_e;

  typedef struct packed {
    logic lo_wr;
    logic hi_wr;
    logic lo_rd;
  } bus_op_t;
endpackage

// File: rtl/tmr16_sync.sv
`timescale 1ns/1ps
module tmr16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic fall_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LAST-1:0], pulse_i};
  end

  // previous synchronised level high, current low
  assign fall_o = sh_q[LAST] & ~sh_q[LAST-1];
endmodule

// File: rtl/tmr16_core.sv
`timescale 1ns/1ps
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_op_t           op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              dec_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] latch_o,
  output logic              zero_step_o
);
  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic [DATA_W-1:0] latch_q, latch_d;

  always_comb begin
    latch_d = op_i.lo_wr ? wdata_i : latch_q;
    cnt_d   = cnt_q;
    if (op_i.hi_wr)  cnt_d = {wdata_i, latch_q};
    else if (dec_i)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      latch_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      latch_q <= latch_d;
    end
  end

  // zero-to-all-ones step; a reload in the same cycle suppresses it
  assign zero_step_o = dec_i && (cnt_q == '0) && !op_i.hi_wr;
  assign cnt_o       = cnt_q;
  assign latch_o     = latch_q;
endmodule

// File: rtl/tmr16_flag.sv
`timescale 1ns/1ps
module tmr16_flag
  import tmr16_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  bus_op_t op_i,
  input  logic    zero_step_i,
  output logic    flag_o,
  output logic    armed_o
);
  logic flag_q, armed_q;
  logic fire;

  assign fire = zero_step_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (op_i.hi_wr) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b1;
    end else if (fire) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (op_i.lo_rd) begin
      flag_q  <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/oneshot_timer16.sv
`timescale 1ns/1ps
module oneshot_timer16
  import tmr16_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              mode_i,
  input  logic              pulse_i,
  input  logic              irq_en_i,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DATA_W;

  bus_op_t           op;
  logic              fall;
  logic              dec;
  logic              zero_step;
  logic              armed;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] latch;
  byte_sel_e         sel;

  assign sel      = byte_sel_e'(addr_i);
  assign op.lo_wr = cs_i &  we_i & (sel == SEL_LO);
  assign op.hi_wr = cs_i &  we_i & (sel == SEL_HI);
  assign op.lo_rd = cs_i & ~we_i & (sel == SEL_LO);

  tmr16_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(pulse_i),
    .fall_o (fall)
  );

  assign dec = mode_i ? fall : 1'b1;

  tmr16_core #(.DATA_W(DATA_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .wdata_i    (wdata_i),
    .dec_i      (dec),
    .cnt_o      (cnt),
    .latch_o    (latch),
    .zero_step_o(zero_step)
  );

  tmr16_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .zero_step_i(zero_step),
    .flag_o     (flag_o),
    .armed_o    (armed)
  );

  assign rdata_o = (sel == SEL_HI) ? cnt[CNT_W-1:DATA_W] : cnt[DATA_W-1:0];
  assign irq_o   = flag_o & irq_en_i;
endmodule

// File: rtl/oneshot_timer16_chk.sv
`timescale 1ns/1ps
module oneshot_timer16_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              we_i,
  input logic              addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              mode_i,
  input logic              fall,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] latch,
  input logic              armed,
  input logic              flag_o,
  input logic              irq_o,
  input logic              irq_en_i
);
  logic hw, lw, dec;
  assign hw  = cs_i & we_i & addr_i;
  assign lw  = cs_i & we_i & ~addr_i;
  assign dec = mode_i ? fall : 1'b1;

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (flag_o & irq_en_i));

  // R2
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw |=> latch == $past(wdata_i));

  // R3
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw |=> (cnt[CNT_W-1:DATA_W] == $past(wdata_i)) && !flag_o && armed);

  // R4
  tick_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !hw) |=> cnt == CNT_W'($past(cnt) - CNT_W'(1)));

  // R6
  timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && dec && cnt == '0 && !hw) |=> flag_o && !armed && (cnt == '1));

  // R7
  disarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !hw) |=> !$rose(flag_o));
endmodule

bind oneshot_timer16 oneshot_timer16_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .mode_i  (mode_i),
  .fall    (fall),
  .cnt     (cnt),
  .latch   (latch),
  .armed   (armed),
  .flag_o  (flag_o),
  .irq_o   (irq_o),
  .irq_en_i(irq_en_i)
);

// File: tb/sim_oneshot_timer16.sv
`timescale 1ns/1ps
module sim_oneshot_timer16;
  localparam real CLK_PER = 10.0;
  localparam int  WD_CYC  = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, we, addr, mode, pulse, en;
  logic [7:0] wd;
  logic [7:0] rdata;
  logic       flag, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PER/2) clk = ~clk;

  oneshot_timer16 u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .mode_i(mode), .pulse_i(pulse),
    .irq_en_i(en), .flag_o(flag), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [15:0] m_cnt;
  logic [7:0]  m_lat;
  logic        m_flag, m_arm;
  logic [2:0]  m_s;

  function automatic logic m_dec(logic md, logic [2:0] s);
    return md ? (s[2] & ~s[1]) : 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_lat <= '0; m_flag <= 1'b0; m_arm <= 1'b0; m_s <= '0;
    end else begin
      logic hw, lw, lr, d, step;
      hw   = cs & we & addr;
      lw   = cs & we & ~addr;
      lr   = cs & ~we & ~addr;
      d    = m_dec(mode, m_s);
      step = d && (m_cnt == 16'h0) && !hw;
      if (hw)     m_cnt <= {wd, m_lat};
      else if (d) m_cnt <= m_cnt - 16'd1;
      if (lw) m_lat <= wd;
      if (hw) begin
        m_flag <= 1'b0; m_arm <= 1'b1;
      end else if (step && m_arm) begin
        m_flag <= 1'b1; m_arm <= 1'b0;
      end else if (lr) m_flag <= 1'b0;
      m_s <= {m_s[1:0], pulse};
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (rst_n && !done) begin
      chk("R4/R5 count byte", {8'h0, rdata}, {8'h0, addr ? m_cnt[15:8] : m_cnt[7:0]});
      chk("R6 flag", {15'h0, flag}, {15'h0, m_flag});
      chk("R10 irq", {15'h0, irq}, {15'h0, m_flag & en});
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    cs = 1; we = 1; addr = a; wd = d;
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic rd(input logic a);
    cs = 1; we = 0; addr = a;
    @(negedge clk);
    cs = 0;
  endtask

  task automatic peek(input logic a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    chk(req, {8'h0, rdata}, {8'h0, exp});
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired (R1 run incomplete)");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    cs = 0; we = 0; addr = 0; wd = 0; mode = 1; pulse = 1; en = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 flag in reset", {15'h0, flag}, 16'h0);
    chk("R1 irq in reset", {15'h0, irq}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    peek(0, 8'h00, "R1 low byte");
    peek(1, 8'h00, "R1 high byte");
    chk("R1 flag", {15'h0, flag}, 16'h0);

    wr(0, 8'h05);
    peek(0, 8'h00, "R2 low unchanged");
    peek(1, 8'h00, "R2 high unchanged");

    wr(1, 8'h12);
    peek(1, 8'h12, "R3 high loaded");
    peek(0, 8'h05, "R3 latch copied");

    pulse = 0;
    repeat (4) @(negedge clk);
    peek(0, 8'h04, "R5 one fall");
    repeat (6) @(negedge clk);
    peek(0, 8'h04, "R5 level held low");
    pulse = 1; repeat (3) @(negedge clk);
    pulse = 0; repeat (4) @(negedge clk);
    peek(0, 8'h03, "R5 second fall");

    mode = 1'b0;
    wr(0, 8'h06);
    wr(1, 8'h00);
    peek(0, 8'h06, "R4 loaded");
    repeat (3) @(negedge clk);
    peek(0, 8'h03, "R4 per clock");
    repeat (3) @(negedge clk);
    peek(0, 8'h00, "R4 at zero");
    chk("R6 no flag at zero", {15'h0, flag}, 16'h0);
    @(negedge clk);
    chk("R6 flag on wrap", {15'h0, flag}, 16'h1);
    peek(1, 8'hFF, "R6 wrap high");
    @(negedge clk);
    peek(0, 8'hFE, "R6 keeps counting");

    en = 0; #1;
    chk("R10 gated off", {15'h0, irq}, 16'h0);
    en = 1; #1;
    chk("R10 gated on", {15'h0, irq}, 16'h1);

    rd(1);
    chk("R9 high read keeps flag", {15'h0, flag}, 16'h1);
    rd(0);
    chk("R8 low read clears flag", {15'h0, flag}, 16'h0);

    repeat (65540) @(negedge clk);
    chk("R7 no second flag", {15'h0, flag}, 16'h0);

    wr(0, 8'h02);
    wr(1, 8'h00);
    repeat (2) @(negedge clk);
    wr(1, 8'h00);
    chk("R11 write beats timeout", {15'h0, flag}, 16'h0);
    peek(0, 8'h02, "R11 reloaded");
    repeat (2) @(negedge clk);
    rd(0);
    chk("R11 timeout beats read", {15'h0, flag}, 16'h1);

    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[5:0] == 6'd0) mode = ~mode;
      if (r[10:8] == 3'd0) en = ~en;
      pulse = r[12];
      cs    = (r[15:13] == 3'd0);
      we    = r[16];
      addr  = r[17];
      wd    = addr ? {7'h0, r[18]} : {5'h0, r[21:19]};
      @(negedge clk);
    end
    cs = 0;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule